// File: doc/BRIEF.md
# Queued SPI Command Sequencer

This block is a SPI master that runs a list of serial transfers from a 16-entry queue without help from the processor. Each queue slot holds three things: a transmit word, a small command value that sets the transfer length, and a receive word. Software fills the transmit and command slots through the queue RAM port. It then programs a start slot, a last slot and the clock settings, and sets the enable bit. The sequencer takes the slots in turn from the start slot. For each slot it shifts the word out most significant bit first and stores the word it receives back into the same slot. At the last slot it raises a done flag. It then either stops or, if wrap mode is on, goes back to the start slot.

The start slot may be changed while the queue is running. The transfer in flight always finishes first, and the next transfer then comes from the new start slot. One chip select frames each transfer. SCK is the system clock divided by an even ratio that software programs.

The queue RAM port has a single write path, which the sequencer also uses to store received words. A host request is taken on a clock edge when `ram_valid` and `ram_ready` are both high. `ram_ready` drops for the one cycle in which the sequencer writes a received word, and the host must then hold its request. A read is answered exactly one cycle after it is accepted, with `ram_rvalid` high. That response cannot be stalled.

Top module: `qspi_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` and `mosi` are 0, every register reads 0, and every command slot holds the value 8.
- R2: A rising edge of the enable bit (control register, address 0, bit 0) starts at the start slot (pointer register, address 1, bits 3:0). The sequencer then runs slots in increasing order, wrapping from 15 to 0, up to the last slot (bits 11:8). At the last slot it sets the done flag and stops. With both pointers at 0 it makes exactly one transfer.
- R3: With wrap mode on (pointer register bit 15), reaching the last slot sets the done flag and continues from the start slot. Clearing enable stops the sequencer once the current transfer completes, and no further transfer follows.
- R4: A pointer register write while idle loads the current pointer at once (status register, address 2, bits 7:4). A write while running does not disturb the transfer in flight. The next slot is then the new start slot.
- R5: The transfer length comes from command bits 3:0. The value 0 gives 16 bits, values 8 to 15 give that many bits, and values 1 to 7 give 8 bits.
- R6: Data leaves most significant bit first. Between transfers SCK rests at the clock polarity (control bit 1). With clock phase 0 (control bit 2) both ends sample on the leading SCK edge; with phase 1 they sample on the trailing edge. An n-bit transfer sends the low n bits of the transmit word.
- R7: The received bits are stored right-justified and zero-extended into the receive slot with the same index.
- R8: Each SCK half period, and the time from the chip select falling to the first SCK edge, is (D+1) clocks, where D is control bits 15:8.
- R9: The done flag (status bit 0) is cleared by writing 1 to it. Writing 0 leaves it unchanged. The status register also shows busy in bit 1.
- R10: RAM port address bits 5:4 select the area: 0 is receive, 1 is transmit, 2 is command. Host writes to the receive area are ignored. Reads of any area other than receive return 0. Read data arrives one cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 pointers, 2 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| ram_valid | input | 1 | Queue RAM request valid |
| ram_ready | output | 1 | Queue RAM request ready |
| ram_we | input | 1 | 1 = write request, 0 = read request |
| ram_addr | input | 6 | Area in bits 5:4, slot in bits 3:0 |
| ram_wdata | input | 16 | Queue RAM write data |
| ram_rvalid | output | 1 | Read response valid |
| ram_rdata | output | 16 | Read response data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select framing each transfer |

## Verification
A corrupted current pointer shows up within a single transfer. The next chip select frame carries the wrong slot's data or bit count, and the receive word lands in a different slot on readback. A wrong shift count or edge-parity choice changes the bits captured from `mosi` in the very frame where it happens. Reflecting `miso` as the complement of `mosi` exposes any receive path that copies the transmit data. Faults in the stop, wrap or deferred-reload decisions appear as an extra, missing or out-of-order frame at the next slot boundary.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_XFER,
    SQ_STORE
  } sq_state_e;

  localparam logic [1:0] RG_CTRL = 2'd0;
  localparam logic [1:0] RG_QPTR = 2'd1;
  localparam logic [1:0] RG_STAT = 2'd2;

  localparam logic [1:0] AREA_RX  = 2'd0;
  localparam logic [1:0] AREA_TX  = 2'd1;
  localparam logic [1:0] AREA_CMD = 2'd2;

  // Length decode: 0 -> 16, 1..7 -> 8, 8..15 -> as written.
  function automatic logic [4:0] len_decode(input logic [3:0] f);
    if (f == 4'd0)      return 5'd16;
    else if (f < 4'd8)  return 5'd8;
    else                return {1'b0, f};
  endfunction

endpackage

// File: rtl/qspi_qram.sv
module qspi_qram #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int CW    = 4,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_valid,
  output logic          h_ready,
  input  logic          h_we,
  input  logic [1:0]    h_area,
  input  logic [PW-1:0] h_idx,
  input  logic [DW-1:0] h_wdata,
  output logic          h_rvalid,
  output logic [DW-1:0] h_rdata,
  input  logic [PW-1:0] s_idx,
  output logic [DW-1:0] s_tx,
  output logic [CW-1:0] s_cmd,
  input  logic          s_rx_we,
  input  logic [DW-1:0] s_rx_data
);
  import qspi_pkg::*;

  logic [DW-1:0] tx_mem  [DEPTH];
  logic [DW-1:0] rx_mem  [DEPTH];
  logic [CW-1:0] cmd_mem [DEPTH];

  // One write path: the sequencer's store cycle takes it from the host.
  assign h_ready = ~s_rx_we;
  assign s_tx    = tx_mem[s_idx];
  assign s_cmd   = cmd_mem[s_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        tx_mem[i]  <= '0;
        rx_mem[i]  <= '0;
        cmd_mem[i] <= CW'(8);
      end
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
    end else begin
      h_rvalid <= h_valid && h_ready && !h_we;
      if (h_valid && h_ready && !h_we)
        h_rdata <= (h_area == AREA_RX) ? rx_mem[h_idx] : '0;
      if (s_rx_we) begin
        rx_mem[s_idx] <= s_rx_data;
      end else if (h_valid && h_we) begin
        case (h_area)
          AREA_TX:  tx_mem[h_idx]  <= h_wdata;
          AREA_CMD: cmd_mem[h_idx] <= h_wdata[CW-1:0];
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter #(
  parameter int DW    = 16,
  parameter int DIV_W = 8,
  localparam int NB_W = $clog2(DW + 1),
  localparam int EC_W = NB_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DW-1:0]    tx_word,
  input  logic [NB_W-1:0]  nbits,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             cs_n,
  output logic             done,
  output logic [DW-1:0]    rx_word
);

  logic             active;
  logic [DIV_W-1:0] hcnt;
  logic [EC_W-1:0]  ecnt;
  logic [NB_W-1:0]  n_q;
  logic             pha_q;
  logic [DW-1:0]    tx_sr;
  logic [DW-1:0]    rx_sr;
  logic             sck_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      hcnt   <= '0;
      ecnt   <= '0;
      n_q    <= '0;
      pha_q  <= 1'b0;
      tx_sr  <= '0;
      rx_sr  <= '0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        sck_q <= cpol;
        if (start) begin
          active <= 1'b1;
          hcnt   <= div;
          ecnt   <= '0;
          n_q    <= nbits;
          pha_q  <= cpha;
          tx_sr  <= tx_word << (DW - int'(nbits));
          rx_sr  <= '0;
        end
      end else if (hcnt != '0) begin
        hcnt <= hcnt - 1'b1;
      end else begin
        hcnt <= div;
        if (ecnt == {n_q, 1'b0}) begin
          active <= 1'b0;
          done_q <= 1'b1;
        end else begin
          sck_q <= ~sck_q;
          // Even edges are leading edges; phase picks which parity samples.
          if (ecnt[0] == pha_q)
            rx_sr <= {rx_sr[DW-2:0], miso};
          else if (ecnt != '0)
            tx_sr <= {tx_sr[DW-2:0], 1'b0};
          ecnt <= ecnt + 1'b1;
        end
      end
    end
  end

  assign sck     = sck_q;
  assign mosi    = active & tx_sr[DW-1];
  assign cs_n    = ~active;
  assign done    = done_q;
  assign rx_word = rx_sr;

endmodule

// File: rtl/qspi_ctrl.sv
module qspi_ctrl #(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          wrap,
  input  logic          qptr_wr,
  input  logic [PW-1:0] newqp_nx,
  input  logic [PW-1:0] endqp,
  input  logic          xfer_done,
  output logic [PW-1:0] cur_ptr,
  output logic          start,
  output logic          rx_we,
  output logic          done_set,
  output logic          busy
);
  import qspi_pkg::*;

  sq_state_e     state;
  logic [PW-1:0] cur;
  logic          pend;
  logic          en_q;
  logic          at_end;
  logic [PW-1:0] cur_inc;

  assign at_end  = (cur == endqp);
  assign cur_inc = (cur == PW'(DEPTH - 1)) ? '0 : cur + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cur   <= '0;
      pend  <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      en_q <= enable;
      case (state)
        SQ_IDLE: begin
          pend <= 1'b0;
          if (qptr_wr) cur <= newqp_nx;
          if (enable && !en_q) begin
            cur   <= newqp_nx;
            state <= SQ_FETCH;
          end
        end
        SQ_FETCH: begin
          if (qptr_wr) pend <= 1'b1;
          state <= SQ_XFER;
        end
        SQ_XFER: begin
          if (qptr_wr) pend <= 1'b1;
          if (xfer_done) state <= SQ_STORE;
        end
        default: begin
          pend <= 1'b0;
          if (!enable || (at_end && !wrap)) begin
            state <= SQ_IDLE;
            if (qptr_wr) cur <= newqp_nx;
          end else begin
            state <= SQ_FETCH;
            cur   <= (at_end || pend || qptr_wr) ? newqp_nx : cur_inc;
          end
        end
      endcase
    end
  end

  assign cur_ptr  = cur;
  assign start    = (state == SQ_FETCH);
  assign rx_we    = (state == SQ_STORE);
  assign done_set = rx_we && at_end;
  assign busy     = (state != SQ_IDLE);

endmodule

// File: rtl/qspi_seq.sv
module qspi_seq #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int DIV_W = 8,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          ram_valid,
  output logic          ram_ready,
  input  logic          ram_we,
  input  logic [5:0]    ram_addr,
  input  logic [DW-1:0] ram_wdata,
  output logic          ram_rvalid,
  output logic [DW-1:0] ram_rdata,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  output logic          cs_n
);
  import qspi_pkg::*;

  localparam int PW   = $clog2(DEPTH);
  localparam int NB_W = $clog2(DW + 1);

  logic [15:0]     ctrl_q;
  logic [15:0]     qptr_q;
  logic            done_q;
  logic            qptr_wr;
  logic [PW-1:0]   newqp_nx;
  logic [PW-1:0]   cur_ptr;
  logic            seq_start, seq_rx_we, seq_done_set, seq_busy;
  logic [DW-1:0]   q_tx, sh_rx;
  logic [CW-1:0]   q_cmd;
  logic            sh_done;
  logic [NB_W-1:0] sh_len;
  logic [15:0]     stat_w;

  assign qptr_wr  = reg_we && (reg_addr == RG_QPTR);
  assign newqp_nx = qptr_wr ? reg_wdata[PW-1:0] : qptr_q[PW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      qptr_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (reg_we && reg_addr == RG_CTRL) ctrl_q <= reg_wdata;
      if (qptr_wr) qptr_q <= reg_wdata;
      if (seq_done_set)
        done_q <= 1'b1;
      else if (reg_we && reg_addr == RG_STAT && reg_wdata[0])
        done_q <= 1'b0;
    end
  end

  always_comb begin
    stat_w          = '0;
    stat_w[0]       = done_q;
    stat_w[1]       = seq_busy;
    stat_w[4 +: PW] = cur_ptr;
  end

  always_comb begin
    case (reg_addr)
      RG_CTRL: reg_rdata = ctrl_q;
      RG_QPTR: reg_rdata = qptr_q;
      RG_STAT: reg_rdata = stat_w;
      default: reg_rdata = '0;
    endcase
  end

  assign sh_len = NB_W'(len_decode(q_cmd[3:0]));

  qspi_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (ctrl_q[0]),
    .wrap     (qptr_q[15]),
    .qptr_wr  (qptr_wr),
    .newqp_nx (newqp_nx),
    .endqp    (qptr_q[8 +: PW]),
    .xfer_done(sh_done),
    .cur_ptr  (cur_ptr),
    .start    (seq_start),
    .rx_we    (seq_rx_we),
    .done_set (seq_done_set),
    .busy     (seq_busy)
  );

  qspi_qram #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_qram (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_valid  (ram_valid),
    .h_ready  (ram_ready),
    .h_we     (ram_we),
    .h_area   (ram_addr[5:4]),
    .h_idx    (ram_addr[PW-1:0]),
    .h_wdata  (ram_wdata),
    .h_rvalid (ram_rvalid),
    .h_rdata  (ram_rdata),
    .s_idx    (cur_ptr),
    .s_tx     (q_tx),
    .s_cmd    (q_cmd),
    .s_rx_we  (seq_rx_we),
    .s_rx_data(sh_rx)
  );

  qspi_shifter #(.DW(DW), .DIV_W(DIV_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (seq_start),
    .tx_word(q_tx),
    .nbits  (sh_len),
    .cpol   (ctrl_q[1]),
    .cpha   (ctrl_q[2]),
    .div    (ctrl_q[8 +: DIV_W]),
    .miso   (miso),
    .sck    (sck),
    .mosi   (mosi),
    .cs_n   (cs_n),
    .done   (sh_done),
    .rx_word(sh_rx)
  );

endmodule

// File: rtl/qspi_seq_chk.sv
module qspi_seq_chk #(
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sck,
  input logic          cs_n,
  input logic          cpol,
  input logic          busy,
  input logic [PW-1:0] cur_ptr,
  input logic          done,
  input logic          done_set,
  input logic          ram_valid,
  input logic          ram_ready,
  input logic          ram_we,
  input logic          ram_rvalid
);

  assert_idle_sck_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> (sck == $past(cpol)));

  assert_cs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(cur_ptr));

  assert_done_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(done_set));

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ready |-> busy);

  assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_valid && ram_ready && !ram_we) |=> ram_rvalid);

endmodule

bind qspi_seq qspi_seq_chk #(.PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sck       (sck),
  .cs_n      (cs_n),
  .cpol      (ctrl_q[1]),
  .busy      (seq_busy),
  .cur_ptr   (cur_ptr),
  .done      (done_q),
  .done_set  (seq_done_set),
  .ram_valid (ram_valid),
  .ram_ready (ram_ready),
  .ram_we    (ram_we),
  .ram_rvalid(ram_rvalid)
);

// File: tb/tb_qspi_seq.sv
`timescale 1ns/1ps
module tb_qspi_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ram_valid = 1'b0;
  logic        ram_ready;
  logic        ram_we = 1'b0;
  logic [5:0]  ram_addr = '0;
  logic [15:0] ram_wdata = '0;
  logic        ram_rvalid;
  logic [15:0] ram_rdata;
  logic        sck, mosi, miso, cs_n;

  always #5 clk = ~clk;
  assign miso = ~mosi;

  qspi_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ram_valid(ram_valid),
    .ram_ready(ram_ready), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rvalid(ram_rvalid), .ram_rdata(ram_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  bit          cpol_b = 0, cpha_b = 0, mon_on = 0;
  realtime     exp_hp = 10.0;
  realtime     last_t = 0.0;
  int          hp_bad = 0;
  logic [15:0] cap;
  int          capn;
  int          mon_n = 0;
  logic [15:0] mon_d [64];
  int          mon_b [64];
  logic [15:0] tx_m  [16];
  logic [3:0]  cmd_m [16];
  int          exp_p [16];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [3:0] c);
    if (c == 0) return 16;
    if (c < 8) return 8;
    return int'(c);
  endfunction

  // Bench-side SPI slave probe
  always @(negedge cs_n) if (mon_on) begin
    cap = '0; capn = 0; last_t = $realtime;
    chk(sck === cpol_b, "R6 sck rest level", int'(sck), int'(cpol_b));
  end
  always @(sck) if (mon_on && cs_n === 1'b0) begin
    if ($realtime - last_t != exp_hp) hp_bad++;
    last_t = $realtime;
    if ((sck !== cpol_b) ^ cpha_b) begin
      cap = {cap[14:0], mosi};
      capn++;
    end
  end
  always @(posedge cs_n) if (mon_on && mon_n < 64) begin
    mon_d[mon_n] = cap; mon_b[mon_n] = capn; mon_n++;
  end

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic ram_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!ram_ready) @(negedge clk);
    ram_valid = 1; ram_we = 1; ram_addr = a; ram_wdata = d;
    @(negedge clk); ram_valid = 0; ram_we = 0;
  endtask

  task automatic ram_rd(input logic [5:0] a, output logic [15:0] d, output bit v);
    @(negedge clk);
    while (!ram_ready) @(negedge clk);
    ram_valid = 1; ram_we = 0; ram_addr = a;
    @(negedge clk); ram_valid = 0; v = ram_rvalid; d = ram_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    repeat (3) @(negedge clk);
    forever begin rd_reg(2'd2, s); if (!s[1]) break; end
  endtask

  task automatic set_mode(input int m, input int dv);
    cpol_b = m[0]; cpha_b = m[1]; exp_hp = (dv + 1) * 10.0;
    wr_reg(2'd0, {8'(dv), 5'd0, cpha_b, cpol_b, 1'b0});
  endtask

  task automatic run_q(input int np, input int ep, input bit wr, input int m, input int dv);
    set_mode(m, dv);
    wr_reg(2'd1, {wr, 3'd0, 4'(ep), 4'd0, 4'(np)});
    mon_n = 0; hp_bad = 0;
    wr_reg(2'd0, {8'(dv), 5'd0, cpha_b, cpol_b, 1'b1});
    wait_idle();
    wr_reg(2'd0, {8'(dv), 5'd0, cpha_b, cpol_b, 1'b0});
  endtask

  task automatic chk_log(input int cnt);
    logic [15:0] d; bit v;
    chk(mon_n == cnt, "R2 transfer count", mon_n, cnt);
    for (int i = 0; i < cnt && i < mon_n; i++) begin
      int p, n; logic [15:0] mk;
      p = exp_p[i]; n = len_of(cmd_m[p]);
      mk = 16'((32'd1 << n) - 1);
      chk(mon_b[i] == n, "R5 bit count", mon_b[i], n);
      chk(mon_d[i] == (tx_m[p] & mk), "R6 mosi word", int'(mon_d[i]), int'(tx_m[p] & mk));
      ram_rd({2'd0, 4'(p)}, d, v);
      chk(v && d == (~tx_m[p] & mk), "R7 rx slot", int'(d), int'(~tx_m[p] & mk));
    end
    chk(hp_bad == 0, "R8 half period", hp_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog actual=running expected=idle");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] s, d0, d1; bit v; int n0;
    for (int i = 0; i < 16; i++) begin tx_m[i] = '0; cmd_m[i] = 4'd8; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n === 1'b1, "R1 cs_n", int'(cs_n), 1);
    chk(sck === 1'b0, "R1 sck", int'(sck), 0);
    chk(mosi === 1'b0, "R1 mosi", int'(mosi), 0);
    for (int a = 0; a < 3; a++) begin
      rd_reg(2'(a), s);
      chk(s == 0, "R1 register", int'(s), 0);
    end
    mon_on = 1;

    // R2 single transfer with both pointers 0; R1 default 8-bit command
    tx_m[0] = 16'hC35A;
    ram_wr(6'h10, tx_m[0]);
    exp_p[0] = 0;
    run_q(0, 0, 0, 0, 1);
    chk_log(1);

    // Sweep over all four modes, several lengths and dividers
    for (int m = 0; m < 4; m++) begin
      logic [3:0] lens [4];
      lens[0] = 4'd8; lens[1] = 4'd12; lens[2] = 4'd0; lens[3] = 4'd3;
      for (int p = 0; p < 4; p++) begin
        cmd_m[p] = lens[(p + m) % 4];
        tx_m[p]  = 16'(p * 16'h1357 + m * 16'h2468) ^ 16'hA5C3;
        ram_wr({2'd2, 4'(p)}, {12'hFFF, cmd_m[p]});
        ram_wr({2'd1, 4'(p)}, tx_m[p]);
        exp_p[p] = p;
      end
      run_q(0, 3, 0, m, m);
      chk_log(4);
      rd_reg(2'd2, s);
      chk(s[0] == 1'b1, "R2 done flag", int'(s[0]), 1);
      wr_reg(2'd2, 16'h0001);
    end

    // R9 done flag write-one-to-clear
    run_q(2, 2, 0, 1, 0);
    rd_reg(2'd2, s);
    chk(s[0] == 1'b1, "R9 done set", int'(s[0]), 1);
    wr_reg(2'd2, 16'h0000);
    rd_reg(2'd2, s);
    chk(s[0] == 1'b1, "R9 write 0 keeps", int'(s[0]), 1);
    wr_reg(2'd2, 16'h0001);
    rd_reg(2'd2, s);
    chk(s[0] == 1'b0, "R9 write 1 clears", int'(s[0]), 0);

    // R4 idle pointer load
    wr_reg(2'd1, 16'h0707);
    rd_reg(2'd2, s);
    chk(s[7:4] == 4'd7, "R4 idle load", int'(s[7:4]), 7);

    // R4 start pointer write during a transfer
    for (int p = 0; p < 6; p++) begin
      tx_m[p] = 16'h1000 * p[15:0] + 16'h0F0F; cmd_m[p] = 4'd0;
      ram_wr({2'd1, 4'(p)}, tx_m[p]);
      ram_wr({2'd2, 4'(p)}, 16'h0000);
    end
    set_mode(0, 2);
    wr_reg(2'd1, 16'h0500);
    mon_n = 0; hp_bad = 0;
    wr_reg(2'd0, 16'h0201);
    @(negedge cs_n);
    repeat (5) @(negedge clk);
    wr_reg(2'd1, 16'h0504);
    chk(cs_n === 1'b0, "R4 transfer not cut", int'(cs_n), 0);
    wait_idle();
    wr_reg(2'd0, 16'h0200);
    exp_p[0] = 0; exp_p[1] = 4; exp_p[2] = 5;
    chk_log(3);

    // R3 wraparound and stop on enable clear
    cmd_m[1] = 4'd9; cmd_m[2] = 4'd8;
    ram_wr(6'h21, 16'h0009); ram_wr(6'h22, 16'h0008);
    set_mode(3, 0);
    wr_reg(2'd1, 16'h8201);
    mon_n = 0;
    wr_reg(2'd0, 16'h0007);
    while (mon_n < 5) @(negedge clk);
    wr_reg(2'd0, 16'h0006);
    n0 = mon_n;
    wait_idle();
    chk(mon_n == n0 || mon_n == n0 + 1, "R3 stop after current", mon_n, n0);
    for (int i = 0; i < mon_n && i < 8; i++) begin
      int p; p = (i % 2 == 0) ? 1 : 2;
      chk(mon_d[i] == (tx_m[p] & 16'((32'd1 << len_of(cmd_m[p])) - 1)),
          "R3 wrap order", int'(mon_d[i]), int'(tx_m[p]));
    end
    rd_reg(2'd2, s);
    chk(s[0] == 1'b1, "R3 done on wrap", int'(s[0]), 1);
    n0 = mon_n;
    repeat (200) @(negedge clk);
    chk(mon_n == n0, "R3 no further transfer", mon_n, n0);

    // R10 area rules
    ram_rd(6'h05, d0, v);
    chk(v, "R10 read latency", int'(v), 1);
    ram_wr(6'h05, ~d0);
    ram_rd(6'h05, d1, v);
    chk(d1 == d0, "R10 rx write ignored", int'(d1), int'(d0));
    ram_rd(6'h11, d1, v);
    chk(v && d1 == 16'h0, "R10 tx read zero", int'(d1), 0);
    ram_rd(6'h21, d1, v);
    chk(v && d1 == 16'h0, "R10 cmd read zero", int'(d1), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule